// File: doc/BRIEF.md
# Interrupt Pending and Vector Unit

This block keeps one pending flag for each of eight interrupt sources and presents the code address of the interrupt the core should service next. A flag is raised by a one-cycle event strobe from its source, or by the core writing a one into the pending register. The flag stays set until the core reports, through an acknowledge strobe carrying the bit index, that it has taken that vector.

Two of the eight flags are overrun interrupts. Each is shared by a pair of capture channels. Every channel overrun is latched in a small per-channel pend register and gated by a per-channel mask register. The shared flag is raised when the masked OR of its pair goes from low to high. Software reads the per-channel pend register to learn which channel fired, and that read clears it.

An enable register gates which pending flags may request service. Bit 7 is the non-maskable source and ignores the enable register. The request output and the vector follow the highest-numbered enabled pending flag.

Top module: `intv_unit`

## Requirements
- R1: After reset the pending (0x12), enable (0x13), channel mask (0x14) and channel pend (0x15) registers read 0x00, `irq_o` is low and `vec_o` is 0.
- R2: A high `src_evt_i[i]` sets pending bit i at the next clock edge. Bit 7 is the non-maskable source, bits 6 and 5 are the external pins, bit 4 is the channel 2/3 overrun, bit 3 is the channel 0/1 overrun, and bits 2..0 are capture/compare channels 3..1.
- R3: A write to 0x12 ORs the written ones into the pending bits. Written zeros change nothing.
- R4: `ack_i` with index `ack_idx_i` clears that pending bit at the next edge. If a hardware or software set of the same bit arrives in the same cycle, the bit stays set.
- R5: `irq_o` is high exactly when some pending bit i is set with enable bit i (register 0x13) set. Bit 7 counts as always enabled.
- R6: While `irq_o` is high, `vec_o` equals 0xFF2030 + 2*i, where i is the highest enabled pending bit. While `irq_o` is low, `vec_o` is 0.
- R7: A high `ovr_evt_i[c]` sets bit c of register 0x15 at the next edge. Bit c of register 0x14 masks channel c. Channels 0,1 feed pending bit 3 and channels 2,3 feed pending bit 4. A shared pending bit is set one edge after its masked OR rises from 0 to 1.
- R8: Asserting `rd_en_i` at address 0x15 returns the channel pend bits and clears them at the edge. A channel event in that same cycle keeps its bit set.
- R9: An overrun from a masked channel does not set a shared pending bit. A masked OR that stays high does not set the shared bit again after it has been acknowledged.
- R10: Writes to 0x13 and 0x14 store the data, and reads return it. Register 0x15 cannot be written, and other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_evt_i | input | 8 | Per-bit one-cycle set strobes |
| ovr_evt_i | input | 4 | Per-channel overrun strobes |
| addr_i | input | 8 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (clears channel pend at 0x15) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| ack_i | input | 1 | Vector taken strobe |
| ack_idx_i | input | 3 | Index of the taken vector |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 24 | Vector address of the selected interrupt |

## Verification
The bench builds the block with its default parameters: eight sources, two shared overrun groups of two channels each, a vector base of 0xFF2030 and a step of 2. With these values all eight vector addresses can be reached. Each group can be set up with one masked and one unmasked channel, and a channel event can land on the same edge as a clear-on-read or an acknowledge. The edge-only rule on the shared bits can also be shown by holding a masked OR high across an acknowledge.

// File: rtl/intv_pkg.sv
package intv_pkg;
  typedef enum logic [1:0] {
    SEL_PEND  = 2'd0,
    SEL_EN    = 2'd1,
    SEL_OMASK = 2'd2,
    SEL_OPEND = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic     hit;
    reg_sel_e sel;
  } reg_dec_t;
endpackage

// File: rtl/intv_ovr_grp.sv
module intv_ovr_grp #(
  parameter int FAN = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [FAN-1:0] evt_i,
  input  logic           wr_mask_i,
  input  logic [FAN-1:0] wmask_i,
  input  logic           rd_clr_i,
  output logic [FAN-1:0] mask_o,
  output logic [FAN-1:0] pend_o,
  output logic           rise_o
);
  logic [FAN-1:0] mask_q, pend_q;
  logic           lvl, lvl_q;

  assign lvl    = |(mask_q & pend_q);
  assign rise_o = lvl & ~lvl_q;
  assign mask_o = mask_q;
  assign pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      pend_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      if (wr_mask_i) mask_q <= wmask_i;
      // event wins over clear-on-read
      pend_q <= (rd_clr_i ? '0 : pend_q) | evt_i;
      lvl_q  <= lvl;
    end
  end

  AST_CLR_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && evt_i == '0) |=> (pend_q == '0)); // R8
  AST_EVT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((pend_q & $past(evt_i)) == $past(evt_i))); // R8
  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R9
endmodule

// File: rtl/intv_pend.sv
module intv_pend #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;  // set beats clear
  end

  assign pend_o = pend_q;

  AST_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i))); // R2
  AST_DROP_NEEDS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(pend_q) & ~pend_q & ~$past(clr_i)) == '0)); // R3
endmodule

// File: rtl/intv_prio.sv
module intv_prio #(
  parameter int                N        = 8,
  parameter int                VEC_W    = 24,
  parameter logic [VEC_W-1:0]  VEC_BASE = 24'hFF2030,
  parameter int                VEC_STEP = 2,
  parameter int                NMI_BIT  = N - 1,
  localparam int               IDX_W    = $clog2(N)
) (
  input  logic [N-1:0]     pend_i,
  input  logic [N-1:0]     en_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [N-1:0]     eff;
  logic [IDX_W-1:0] sel;
  logic             any;

  always_comb begin
    eff          = pend_i & en_i;
    eff[NMI_BIT] = pend_i[NMI_BIT];
    sel = '0;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (eff[i]) begin
        sel = IDX_W'(i);  // later (higher) bit overrides
        any = 1'b1;
      end
    end
  end

  assign irq_o = any;
  assign vec_o = any ? (VEC_BASE + VEC_W'(VEC_STEP) * VEC_W'(sel)) : '0;
endmodule

// File: rtl/intv_unit.sv
module intv_unit #(
  parameter int                 NUM_IRQ    = 8,
  parameter int                 ADDR_W     = 8,
  parameter int                 VEC_W      = 24,
  parameter logic [VEC_W-1:0]   VEC_BASE   = 24'hFF2030,
  parameter int                 VEC_STEP   = 2,
  parameter int                 OVR_GRP    = 2,
  parameter int                 OVR_FAN    = 2,
  parameter int                 OVR_LSB    = 3,
  parameter logic [ADDR_W-1:0]  PEND_ADDR  = 8'h12,
  parameter logic [ADDR_W-1:0]  EN_ADDR    = 8'h13,
  parameter logic [ADDR_W-1:0]  OMASK_ADDR = 8'h14,
  parameter logic [ADDR_W-1:0]  OPEND_ADDR = 8'h15,
  localparam int                IDX_W      = $clog2(NUM_IRQ),
  localparam int                OVR_CH     = OVR_GRP * OVR_FAN
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] src_evt_i,
  input  logic [OVR_CH-1:0]  ovr_evt_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [NUM_IRQ-1:0] wdata_i,
  output logic [NUM_IRQ-1:0] rdata_o,
  input  logic               ack_i,
  input  logic [IDX_W-1:0]   ack_idx_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o
);
  import intv_pkg::*;

  localparam int NMI_BIT = NUM_IRQ - 1;

  reg_dec_t           dec;
  logic [NUM_IRQ-1:0] pend_q, en_q, set_vec, clr_vec;
  logic [OVR_CH-1:0]  omask, opend;
  logic [OVR_GRP-1:0] ovr_rise;
  logic               wr_pend, wr_en_reg, wr_omask, rd_opend;

  always_comb begin
    dec.hit = 1'b1;
    dec.sel = SEL_PEND;
    case (addr_i)
      PEND_ADDR:  dec.sel = SEL_PEND;
      EN_ADDR:    dec.sel = SEL_EN;
      OMASK_ADDR: dec.sel = SEL_OMASK;
      OPEND_ADDR: dec.sel = SEL_OPEND;
      default:    dec.hit = 1'b0;
    endcase
  end

  assign wr_pend   = wr_en_i && dec.hit && dec.sel == SEL_PEND;
  assign wr_en_reg = wr_en_i && dec.hit && dec.sel == SEL_EN;
  assign wr_omask  = wr_en_i && dec.hit && dec.sel == SEL_OMASK;
  assign rd_opend  = rd_en_i && dec.hit && dec.sel == SEL_OPEND;

  for (genvar g = 0; g < OVR_GRP; g++) begin : g_ovr
    intv_ovr_grp #(.FAN(OVR_FAN)) u_grp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (ovr_evt_i[g*OVR_FAN +: OVR_FAN]),
      .wr_mask_i (wr_omask),
      .wmask_i   (wdata_i[g*OVR_FAN +: OVR_FAN]),
      .rd_clr_i  (rd_opend),
      .mask_o    (omask[g*OVR_FAN +: OVR_FAN]),
      .pend_o    (opend[g*OVR_FAN +: OVR_FAN]),
      .rise_o    (ovr_rise[g])
    );
  end

  always_comb begin
    set_vec = src_evt_i | (wr_pend ? wdata_i : '0);
    for (int g = 0; g < OVR_GRP; g++) set_vec[OVR_LSB+g] = set_vec[OVR_LSB+g] | ovr_rise[g];
  end

  assign clr_vec = ack_i ? (NUM_IRQ'(1) << ack_idx_i) : '0;

  intv_pend #(.N(NUM_IRQ)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .pend_o (pend_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= '0;
    else if (wr_en_reg) en_q <= wdata_i;
  end

  intv_prio #(
    .N        (NUM_IRQ),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP),
    .NMI_BIT  (NMI_BIT)
  ) u_prio (
    .pend_i (pend_q),
    .en_i   (en_q),
    .irq_o  (irq_o),
    .vec_o  (vec_o)
  );

  always_comb begin
    rdata_o = '0;
    if (dec.hit) begin
      case (dec.sel)
        SEL_PEND:  rdata_o = pend_q;
        SEL_EN:    rdata_o = en_q;
        SEL_OMASK: rdata_o = NUM_IRQ'(omask);
        SEL_OPEND: rdata_o = NUM_IRQ'(opend);
        default:   rdata_o = '0;
      endcase
    end
  end

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !set_vec[ack_idx_i]) |=> !pend_q[$past(ack_idx_i)]); // R4
  AST_NMI_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q[NMI_BIT] |-> (irq_o && vec_o == VEC_BASE + VEC_W'(VEC_STEP * NMI_BIT))); // R5
  AST_VEC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (vec_o == '0)); // R6
  AST_VEC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vec_o >= VEC_BASE && vec_o <= VEC_BASE + VEC_W'(VEC_STEP * (NUM_IRQ - 1)))); // R6
  AST_EN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_reg |=> (en_q == $past(wdata_i))); // R10
endmodule

// File: tb/intv_unit_bench.sv
`timescale 1ns/1ps
module intv_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src_evt = '0;
  logic [3:0]  ovr_evt = '0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic        ack = 1'b0;
  logic [2:0]  ack_idx = '0;
  logic [7:0]  rdata;
  logic        irq;
  logic [23:0] vec;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] m_pend = '0, m_en = '0;
  logic [3:0] m_omask = '0, m_opend = '0;
  logic [1:0] m_lvl = '0;

  always #10 clk = ~clk;

  intv_unit u_intv_unit (
    .clk_i(clk), .rst_ni(rst_n), .src_evt_i(src_evt), .ovr_evt_i(ovr_evt),
    .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata),
    .rdata_o(rdata), .ack_i(ack), .ack_idx_i(ack_idx), .irq_o(irq), .vec_o(vec)
  );

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish act=hung exp=done");
    summary();
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] eff_pend();
    return m_pend & (m_en | 8'h80);
  endfunction

  function automatic logic [23:0] exp_vec();
    logic [7:0] e = eff_pend();
    for (int i = 7; i >= 0; i--) if (e[i]) return 24'hFF2030 + 24'(2 * i);
    return 24'h0;
  endfunction

  function automatic logic [2:0] top_idx();
    logic [7:0] e = eff_pend();
    for (int i = 7; i >= 0; i--) if (e[i]) return 3'(i);
    return 3'd0;
  endfunction

  function automatic logic [7:0] exp_rd(logic [7:0] a);
    case (a)
      8'h12:   return m_pend;
      8'h13:   return m_en;
      8'h14:   return {4'h0, m_omask};
      8'h15:   return {4'h0, m_opend};
      default: return 8'h00;
    endcase
  endfunction

  // one clock with the given stimulus; outputs compared before the edge, model advanced at it
  task automatic cyc(logic [7:0] e, logic [3:0] o, logic w, logic r, logic [7:0] a,
                     logic [7:0] d, logic k, logic [2:0] ki, string tag);
    logic [1:0] lvl;
    logic [7:0] setv;
    src_evt = e; ovr_evt = o; wr_en = w; rd_en = r; addr = a; wdata = d; ack = k; ack_idx = ki;
    #1;
    check({tag, " irq"}, 32'(irq), 32'(eff_pend() != 0));
    check({tag, " vec"}, 32'(vec), 32'(exp_vec()));
    check({tag, " rdata"}, 32'(rdata), 32'(exp_rd(a)));
    @(posedge clk);
    lvl[0] = |(m_opend[1:0] & m_omask[1:0]);
    lvl[1] = |(m_opend[3:2] & m_omask[3:2]);
    setv = e | ((w && a == 8'h12) ? d : 8'h00);
    setv[3] = setv[3] | (lvl[0] & ~m_lvl[0]);
    setv[4] = setv[4] | (lvl[1] & ~m_lvl[1]);
    m_pend = (m_pend & ~(k ? (8'h01 << ki) : 8'h00)) | setv;
    if (w && a == 8'h13) m_en = d;
    if (w && a == 8'h14) m_omask = d[3:0];
    m_opend = ((r && a == 8'h15) ? 4'h0 : m_opend) | o;
    m_lvl = lvl;
    @(negedge clk);
    src_evt = '0; ovr_evt = '0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0; ack = 1'b0;
  endtask

  task automatic idle(string tag);
    cyc(8'h00, 4'h0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 3'd0, tag);
  endtask
  task automatic hw(logic [7:0] e, string tag);
    cyc(e, 4'h0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 3'd0, tag);
  endtask
  task automatic wreg(logic [7:0] a, logic [7:0] d, string tag);
    cyc(8'h00, 4'h0, 1'b1, 1'b0, a, d, 1'b0, 3'd0, tag);
  endtask
  task automatic ackb(logic [2:0] i, string tag);
    cyc(8'h00, 4'h0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, i, tag);
  endtask

  task automatic chk_reg(string tag, logic [7:0] a, logic [7:0] exp);
    addr = a; rd_en = 1'b0; wr_en = 1'b0;
    #1;
    check(tag, 32'(rdata), 32'(exp));
  endtask

  task automatic chk_out(string tag, logic exp_irq, logic [23:0] exp_v);
    #1;
    check({tag, " irq"}, 32'(irq), 32'(exp_irq));
    check({tag, " vec"}, 32'(vec), 32'(exp_v));
  endtask

  initial begin
    logic [7:0] ra, rw;
    logic [2:0] ri;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_out("R1 reset", 1'b0, 24'h0);
    chk_reg("R1 pend reset", 8'h12, 8'h00);
    chk_reg("R1 en reset", 8'h13, 8'h00);
    chk_reg("R1 omask reset", 8'h14, 8'h00);
    chk_reg("R1 opend reset", 8'h15, 8'h00);

    hw(8'h02, "R2 set");
    chk_reg("R2 pend bit1", 8'h12, 8'h02);
    chk_out("R5 disabled", 1'b0, 24'h0);

    wreg(8'h13, 8'hFF, "R10 en wr");
    chk_reg("R10 en readback", 8'h13, 8'hFF);
    chk_out("R6 vec bit1", 1'b1, 24'hFF2032);

    hw(8'h40, "R2 set bit6");
    chk_out("R6 vec bit6", 1'b1, 24'hFF203C);

    ackb(3'd6, "R4 ack");
    chk_out("R4 after ack6", 1'b1, 24'hFF2032);
    chk_reg("R4 pend after ack6", 8'h12, 8'h02);

    cyc(8'h02, 4'h0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 3'd1, "R4 set vs ack");
    chk_reg("R4 set wins", 8'h12, 8'h02);
    cyc(8'h00, 4'h0, 1'b1, 1'b0, 8'h12, 8'h02, 1'b1, 3'd1, "R4 sw set vs ack");
    chk_reg("R4 sw set wins", 8'h12, 8'h02);

    ackb(3'd1, "R4 ack1");
    chk_out("R6 idle vec", 1'b0, 24'h0);

    wreg(8'h12, 8'h21, "R3 sw set");
    chk_reg("R3 or-in", 8'h12, 8'h21);
    wreg(8'h12, 8'h00, "R3 zero wr");
    chk_reg("R3 zero no effect", 8'h12, 8'h21);
    chk_out("R3 sw raises", 1'b1, 24'hFF203A);

    wreg(8'h13, 8'h00, "R5 mask all");
    chk_out("R5 masked", 1'b0, 24'h0);
    hw(8'h80, "R5 nmi");
    chk_out("R5 nmi unmaskable", 1'b1, 24'hFF203E);
    ackb(3'd7, "R4 a7"); ackb(3'd5, "R4 a5"); ackb(3'd0, "R4 a0");
    chk_reg("R4 all cleared", 8'h12, 8'h00);

    // overrun decode
    cyc(8'h00, 4'h2, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 3'd0, "R7 ch1");
    chk_reg("R7 opend ch1", 8'h15, 8'h02);
    idle("R9 idle");
    chk_reg("R9 masked ch no set", 8'h12, 8'h00);
    wreg(8'h14, 8'h02, "R7 unmask ch1");
    idle("R7 idle");
    chk_reg("R7 shared bit3", 8'h12, 8'h08);
    ackb(3'd3, "R9 ack3");
    idle("R9 hold1"); idle("R9 hold2");
    chk_reg("R9 level no reset", 8'h12, 8'h00);
    cyc(8'h00, 4'h0, 1'b0, 1'b1, 8'h15, 8'h00, 1'b0, 3'd0, "R8 read");
    chk_reg("R8 cleared on read", 8'h15, 8'h00);
    cyc(8'h00, 4'h1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 3'd0, "R7 ch0");
    idle("R9 idle2");
    chk_reg("R9 ch0 masked", 8'h12, 8'h00);
    cyc(8'h00, 4'h1, 1'b0, 1'b1, 8'h15, 8'h00, 1'b0, 3'd0, "R8 read vs evt");
    chk_reg("R8 event wins", 8'h15, 8'h01);
    wreg(8'h14, 8'h0D, "R7 mask wr");
    chk_reg("R10 omask readback", 8'h14, 8'h0D);
    wreg(8'h15, 8'hFF, "R10 opend ro");
    chk_reg("R10 opend not writable", 8'h15, 8'h01);
    chk_reg("R7 group0 via mask", 8'h12, 8'h08);
    cyc(8'h00, 4'h8, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 3'd0, "R7 ch3");
    idle("R7 idle3");
    chk_reg("R7 group1 bit4", 8'h12, 8'h18);
    chk_reg("R10 unmapped", 8'h20, 8'h00);

    // random traffic checked against the bench model
    for (int n = 0; n < 3000; n++) begin
      case ($urandom_range(0, 4))
        0: ra = 8'h12; 1: ra = 8'h13; 2: ra = 8'h14; 3: ra = 8'h15; default: ra = 8'h20;
      endcase
      rw = 8'($urandom) & 8'($urandom);
      ri = ($urandom_range(0, 1) == 0) ? top_idx() : 3'($urandom);
      cyc(($urandom_range(0, 3) == 0) ? (8'($urandom) & 8'($urandom) & 8'($urandom)) : 8'h00,
          ($urandom_range(0, 3) == 0) ? (4'($urandom) & 4'($urandom)) : 4'h0,
          $urandom_range(0, 5) == 0, $urandom_range(0, 3) == 0, ra, rw,
          $urandom_range(0, 2) == 0, ri, "R2/R3/R4/R5/R6/R7/R8 random");
    end
    summary();
  end
endmodule